// File: doc/BRIEF.md
# Ternary Line Test Pattern Generator

This block drives a fixed, repeatable stream of three-level line symbols so that a 100 Mb/s twisted-pair transmitter can be measured against its signal-quality limits. It emits one symbol for each bit-time enable, where one bit time is 8 ns. Each symbol is a signed ternary value (+1, 0 or -1) on a two-bit bus, with a valid flag beside it.

A small write-only control port holds four configuration words. Together they pick one of several streams. The default is scrambled idle. The other choices are a long-pulse waveform for amplitude and overshoot tests, a short two-bit-time waveform for duty-cycle distortion, and a pseudo-random self-test stream. Idle and the self-test stream pass through an MLT-3 level tracker. The two pulse waveforms are produced directly as levels. Clearing the fast-speed force bit silences the output.

Top module: `ternary_test_gen`

## Requirements
- R1: The generator state and the registered outputs change only on a clock edge where `bit_en` is high. With `bit_en` low, `sym` and `sym_vld` hold their values.
- R2: `sym` uses the encoding 2'b01 = +1, 2'b00 = 0 and 2'b11 = -1. The code 2'b10 never appears.
- R3: Long-pulse mode repeats a 40-symbol period: 14 symbols of +1, 6 of 0, 14 of -1, then 6 of 0.
- R4: Short-pulse mode repeats the six symbols +1, +1, 0, 0, -1, -1.
- R5: Bits [2:0] of the test word (select 1) hold the test code. Code 7 selects long-pulse and code 6 selects short-pulse. Any other code enables no pattern. An enabled pattern takes priority over the self-test stream.
- R6: With the speed force set and no pattern or self-test active, the output is scrambled idle. Each code bit is the inverse of bit 10 of an 11-bit scrambler. The scrambler shifts left and takes bit10 XOR bit8 as its new bit 0 (x^11 + x^9 + 1). Its seed is all ones, it is never all zeros, and the code bits are MLT-3 encoded.
- R7: Bit 8 of the self-test word (select 3) starts a PRBS9 stream. The start is honoured only while the good-link bit, bit 0 of select 2, is set. PRBS9 outputs bit 8 of its state, shifts left and takes bit8 XOR bit4 as its new bit 0 (x^9 + x^5 + 1). Its seed is 9'h1FF, its state is never zero, and the bits are MLT-3 encoded.
- R8: In MLT-3, a 1 advances the level along 0, +1, 0, -1 and a 0 holds the level. A fresh encoder sits at 0, and its first 1 goes to +1. Within one run the level never jumps directly between +1 and -1.
- R9: A configuration change takes effect at the next bit-time enable. The newly selected stream starts at its first symbol: the pulse counters restart, the scrambler and PRBS are reseeded, and MLT-3 returns to level 0.
- R10: When bit 0 of the speed word (select 0) is clear, each enable yields `sym` = 2'b00 and `sym_vld` = 0.
- R11: Reset sets the speed force, clears the test code, link and start bits, reloads both seeds, clears MLT-3 to level 0, and drives `sym` = 2'b00 and `sym_vld` = 0 until the first enable. After the first enable, the output is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-time enable; one symbol per high cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 speed, 1 test, 2 link, 3 self-test |
| cfg_wdata | input | 16 | Configuration write data |
| sym | output | 2 | Ternary line symbol |
| sym_vld | output | 1 | Symbol valid |

## Verification
The bench steps through the modes one at a time and compares every emitted symbol against an arithmetic model. The model runs for several full periods of the long and short waveforms, which shows that the phase counts and wrap points are correct. Long runs of idle and PRBS9 separate the two scrambler polynomials and seeds, and also check the MLT-3 level rules. Configuration changes made mid-stream confirm three things: a restart lands on the first symbol, code 5 counts as no pattern, and the self-test start bit has no effect without the link bit. Enable gaps, clearing the speed force, and a mid-run reset cover the hold, silence and reset behaviour.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [2:0] {
    MODE_OFF, MODE_IDLE, MODE_LONG, MODE_SHORT, MODE_PRBS
  } tpg_mode_e;

  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_NEG  = 2'b11;

  localparam logic [1:0] SEL_SPEED = 2'd0;
  localparam logic [1:0] SEL_TEST  = 2'd1;
  localparam logic [1:0] SEL_LINK  = 2'd2;
  localparam logic [1:0] SEL_BIST  = 2'd3;

  localparam logic [2:0] TC_LONG  = 3'd7;
  localparam logic [2:0] TC_SHORT = 3'd6;
  localparam int         BIST_BIT = 8;
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int             W    = 9,
  parameter int             TAP  = 5,
  parameter logic [W-1:0]   SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         restart,
  output logic         bit_o,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d, eff;

  always_comb begin
    eff     = restart ? SEED : state_q;
    state_d = state_q;
    if (step) state_d = {eff[W-2:0], eff[W-1] ^ eff[TAP-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign bit_o   = eff[W-1];
  assign state_o = state_q;
endmodule

// File: rtl/tpg_pulse_seq.sv
module tpg_pulse_seq import tpg_pkg::*; #(
  parameter int HI    = 14,
  parameter int GAP_A = 6,
  parameter int GAP_B = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       restart,
  output logic [1:0] sym_o
);
  localparam int PER = 2 * HI + GAP_A + GAP_B;
  localparam int CW  = $clog2(PER + 1);

  logic [CW-1:0] cnt_q, cnt_d, eff;

  always_comb begin
    eff = restart ? '0 : cnt_q;
    if (eff < CW'(HI))                   sym_o = SYM_POS;
    else if (eff < CW'(HI + GAP_A))      sym_o = SYM_ZERO;
    else if (eff < CW'(2 * HI + GAP_A))  sym_o = SYM_NEG;
    else                                 sym_o = SYM_ZERO;
    cnt_d = cnt_q;
    if (step) cnt_d = (eff == CW'(PER - 1)) ? '0 : eff + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tpg_mlt3.sv
module tpg_mlt3 import tpg_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       restart,
  input  logic       bit_i,
  output logic [1:0] level_o
);
  logic [1:0] lvl_q, lvl_d, last_q, last_d, eff_lvl, eff_last;

  always_comb begin
    eff_lvl  = restart ? SYM_ZERO : lvl_q;
    eff_last = restart ? SYM_NEG  : last_q;
    level_o  = eff_lvl;
    last_d   = eff_last;
    if (bit_i) begin
      if (eff_lvl == SYM_ZERO) begin
        level_o = (eff_last == SYM_NEG) ? SYM_POS : SYM_NEG;
      end else begin
        level_o = SYM_ZERO;
        last_d  = eff_lvl;
      end
    end
    lvl_d = level_o;
    if (!step) begin
      lvl_d  = lvl_q;
      last_d = last_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= SYM_ZERO;
      last_q <= SYM_NEG;
    end else begin
      lvl_q  <= lvl_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/ternary_test_gen.sv
module ternary_test_gen import tpg_pkg::*; #(
  parameter int SCR_W    = 11,
  parameter int SCR_TAP  = 9,
  parameter int PRBS_W   = 9,
  parameter int PRBS_TAP = 5,
  parameter int LONG_HI  = 14,
  parameter int LONG_GAP = 6,
  parameter int SHORT_HI = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic [1:0]  sym,
  output logic        sym_vld
);
  logic       force_q, force_d, link_q, link_d, bist_q, bist_d;
  logic [2:0] tcode_q, tcode_d;
  tpg_mode_e  mode_c, mode_q, mode_d;
  logic       restart_c, scr_bit, prbs_bit, mlt_step, mlt_bit;
  logic [1:0] long_sym, short_sym, mlt_sym, sym_d;
  logic       vld_d;
  logic [SCR_W-1:0]  scr_state;
  logic [PRBS_W-1:0] prbs_state;

  // Configuration words
  always_comb begin
    force_d = force_q;
    tcode_d = tcode_q;
    link_d  = link_q;
    bist_d  = bist_q;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_SPEED: force_d = cfg_wdata[0];
        SEL_TEST:  tcode_d = cfg_wdata[2:0];
        SEL_LINK:  link_d  = cfg_wdata[0];
        SEL_BIST:  bist_d  = cfg_wdata[BIST_BIT];
      endcase
    end
  end

  // Mode decode: speed force, then test code, then self-test
  always_comb begin
    if (!force_q)                 mode_c = MODE_OFF;
    else if (tcode_q == TC_LONG)  mode_c = MODE_LONG;
    else if (tcode_q == TC_SHORT) mode_c = MODE_SHORT;
    else if (bist_q && link_q)    mode_c = MODE_PRBS;
    else                          mode_c = MODE_IDLE;
  end

  assign restart_c = bit_en && (mode_c != mode_q);
  assign mode_d    = bit_en ? mode_c : mode_q;
  assign mlt_step  = bit_en && (mode_c == MODE_IDLE || mode_c == MODE_PRBS);
  assign mlt_bit   = (mode_c == MODE_IDLE) ? ~scr_bit : prbs_bit;

  tpg_lfsr #(.W(SCR_W), .TAP(SCR_TAP), .SEED('1)) u_scr (
    .clk(clk), .rst_n(rst_n), .step(bit_en && mode_c == MODE_IDLE),
    .restart(restart_c), .bit_o(scr_bit), .state_o(scr_state));

  tpg_lfsr #(.W(PRBS_W), .TAP(PRBS_TAP), .SEED('1)) u_prbs (
    .clk(clk), .rst_n(rst_n), .step(bit_en && mode_c == MODE_PRBS),
    .restart(restart_c), .bit_o(prbs_bit), .state_o(prbs_state));

  tpg_mlt3 u_mlt (
    .clk(clk), .rst_n(rst_n), .step(mlt_step), .restart(restart_c),
    .bit_i(mlt_bit), .level_o(mlt_sym));

  tpg_pulse_seq #(.HI(LONG_HI), .GAP_A(LONG_GAP), .GAP_B(LONG_GAP)) u_long (
    .clk(clk), .rst_n(rst_n), .step(bit_en && mode_c == MODE_LONG),
    .restart(restart_c), .sym_o(long_sym));

  tpg_pulse_seq #(.HI(SHORT_HI), .GAP_A(SHORT_HI), .GAP_B(0)) u_short (
    .clk(clk), .rst_n(rst_n), .step(bit_en && mode_c == MODE_SHORT),
    .restart(restart_c), .sym_o(short_sym));

  // Output selection
  always_comb begin
    vld_d = 1'b1;
    unique case (mode_c)
      MODE_LONG:  sym_d = long_sym;
      MODE_SHORT: sym_d = short_sym;
      MODE_IDLE,
      MODE_PRBS:  sym_d = mlt_sym;
      default: begin
        sym_d = SYM_ZERO;
        vld_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= 1'b1;
      tcode_q <= '0;
      link_q  <= 1'b0;
      bist_q  <= 1'b0;
      mode_q  <= MODE_IDLE;
      sym     <= SYM_ZERO;
      sym_vld <= 1'b0;
    end else begin
      force_q <= force_d;
      tcode_q <= tcode_d;
      link_q  <= link_d;
      bist_q  <= bist_d;
      mode_q  <= mode_d;
      if (bit_en) begin
        sym     <= sym_d;
        sym_vld <= vld_d;
      end
    end
  end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker import tpg_pkg::*; #(
  parameter int SW = 11,
  parameter int PW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic [1:0]    sym,
  input logic          sym_vld,
  input logic          restart,
  input logic          mlt_step,
  input logic [SW-1:0] scr_state,
  input logic [PW-1:0] prbs_state
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(sym) && $stable(sym_vld)));

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sym != 2'b10);

  assert_scr_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scr_state != '0);

  assert_prbs_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_state != '0);

  assert_no_pos_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mlt_step && !restart && sym == SYM_POS) |=> sym != SYM_NEG);

  assert_no_neg_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mlt_step && !restart && sym == SYM_NEG) |=> sym != SYM_POS);

  assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |-> sym == SYM_ZERO);
endmodule

bind ternary_test_gen tpg_checker #(.SW(SCR_W), .PW(PRBS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sym(sym), .sym_vld(sym_vld),
  .restart(restart_c), .mlt_step(mlt_step),
  .scr_state(scr_state), .prbs_state(prbs_state));

// File: tb/sim_ternary_test_gen.sv
`timescale 1ns/1ps
module sim_ternary_test_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0] sym;
  logic sym_vld;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Bench copy of configuration and stream state
  bit m_force, m_link, m_bist;
  int m_code, pm, idx, lvl, last;
  logic [10:0] scr;
  logic [8:0] prb;

  always #2.5 clk = ~clk;

  ternary_test_gen u0 (.clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .sym(sym), .sym_vld(sym_vld));

  // 0 off, 1 idle, 2 long, 3 short, 4 prbs
  function automatic int cur_mode();
    if (!m_force) return 0;
    if (m_code == 7) return 2;
    if (m_code == 6) return 3;
    if (m_bist && m_link) return 4;
    return 1;
  endfunction

  function automatic logic [1:0] enc(int v);
    return (v == 1) ? 2'b01 : (v == -1) ? 2'b11 : 2'b00;
  endfunction

  task automatic model_reset();
    m_force = 1; m_link = 0; m_bist = 0; m_code = 0;
    pm = 1; idx = 0; lvl = 0; last = -1; scr = '1; prb = '1;
  endtask

  task automatic mlt(bit b);
    if (b) begin
      if (lvl == 0) lvl = -last;
      else begin last = lvl; lvl = 0; end
    end
  endtask

  task automatic model_step(output logic [2:0] e);
    int m, p;
    bit b;
    m = cur_mode();
    if (m != pm) begin
      idx = 0; lvl = 0; last = -1; scr = '1; prb = '1;
    end
    pm = m;
    case (m)
      0: e = 3'b000;
      2: begin
        p = idx % 40;
        e = {1'b1, enc(p < 14 ? 1 : p < 20 ? 0 : p < 34 ? -1 : 0)};
        idx++;
      end
      3: begin
        p = (idx % 6) / 2;
        e = {1'b1, enc(1 - p)};
        idx++;
      end
      1: begin
        b = ~scr[10];
        scr = {scr[9:0], scr[10] ^ scr[8]};
        mlt(b);
        e = {1'b1, enc(lvl)};
      end
      default: begin
        b = prb[8];
        prb = {prb[7:0], prb[8] ^ prb[4]};
        mlt(b);
        e = {1'b1, enc(lvl)};
      end
    endcase
  endtask

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp || got[1:0] == 2'b10) begin
      fails++;
      $display("FAIL %s: got vld/sym %b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      2'd0: m_force = d[0];
      2'd1: m_code = int'(d[2:0]);
      2'd2: m_link = d[0];
      default: m_bist = d[8];
    endcase
  endtask

  task automatic ticks(string tag, int n);
    logic [2:0] e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_en = 1;
      @(negedge clk); bit_en = 0;
      model_step(e);
      check(tag, {sym_vld, sym}, e);
    end
  endtask

  task automatic hold_check(string tag);
    logic [2:0] snap;
    snap = {sym_vld, sym};
    repeat (4) @(negedge clk);
    check(tag, {sym_vld, sym}, snap);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {sym_vld, sym}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    check("R11 no enable after reset", {sym_vld, sym}, 3'b000);
    ticks("R6 R8 R11 idle from reset", 80);
    hold_check("R1 hold in idle");

    wr(2'd1, 16'h0007);
    hold_check("R1 R9 write waits for enable");
    ticks("R3 R5 R9 long pulse", 100);
    wr(2'd1, 16'h0006);
    ticks("R4 R5 R9 short pulse", 30);
    hold_check("R1 hold in short");
    wr(2'd1, 16'h0005);
    ticks("R5 R6 R9 code 5 gives idle", 40);

    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h0100);
    ticks("R7 start ignored without link", 30);
    wr(2'd2, 16'h0001);
    ticks("R7 R8 R9 prbs9", 120);
    wr(2'd1, 16'h0007);
    ticks("R5 pattern over self-test", 45);
    wr(2'd1, 16'h0000);
    ticks("R7 R9 prbs restart", 40);

    wr(2'd0, 16'h0000);
    ticks("R10 speed force clear", 10);
    wr(2'd1, 16'h0006);
    ticks("R10 off overrides pattern", 5);
    wr(2'd0, 16'h0001);
    ticks("R4 R9 short after off", 14);

    @(negedge clk);
    rst_n = 0;
    #1;
    model_reset();
    check("R11 mid-run reset", {sym_vld, sym}, 3'b000);
    @(negedge clk);
    rst_n = 1;
    ticks("R6 R11 idle after reset", 30);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule